// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Engine

This block owns the descriptor table of a simple Ethernet MAC. A host programs the table over a 32-bit register bus: each descriptor is a pair of words, a status/control word and a buffer address word. A split register divides the table into a transmit ring (indices 0 to N-1) and a receive ring (indices N and up). Ownership passes between host and engine through one bit per descriptor: "ready" on the transmit side, "empty" on the receive side.

With transmit enabled, the engine watches the current transmit descriptor. Once the host marks it ready, the engine offers its length and buffer address to the MAC core and waits. When the core finishes, the engine writes the outcome back into the descriptor, returns ownership to the host and moves on. With receive enabled, the engine offers the buffer address of the current empty receive descriptor. When the core reports a finished frame, the engine records its length and status and advances. If a frame arrives while no empty descriptor is available, the frame is dropped and a busy event is raised. Per-descriptor interrupt-enable bits decide whether frame and error events fire. The MAC core itself is outside this block and is reached through a plain handshake.

Top module: `eth_bd_ring_engine`

## Requirements
- R1: After reset, tx_req, rx_ready and every event output are low, the mode register (offset 0x000) reads 0 and the split register (offset 0x020) reads NUM_BD/2.
- R2: Descriptor i is reachable at byte offset 0x400 + 8*i, with the status word at +0 and the address word at +4. Host read data appears on host_rdata in the cycle after the read strobe.
- R3: A value written to the split register that exceeds NUM_BD (128) reads back as NUM_BD. Smaller values read back unchanged.
- R4: While mode bit 1 (transmit enable) is set and the current transmit descriptor has status bit 15 (ready) set, tx_req is raised. tx_len carries status bits 31:16 and tx_buf_addr carries the address word. All three hold steady until tx_done.
- R5: On tx_done the status word is rewritten. Bit 15 is cleared, bits 31:16 and 14:9 are kept, and bits 8:0 take tx_status (bit 8 underrun, 7:4 retry count, 3 retry limit, 2 late collision, 1 deferred, 0 carrier lost).
- R6: The transmit pointer advances by one after each write-back. It returns to index 0 after a descriptor with status bit 13 (wrap) set, or after index N-1.
- R7: If status bit 14 (interrupt enable) is set, a transmit write-back pulses evt_tx_err when any of tx_status bits 8, 3, 2 or 0 is set, and pulses evt_tx_done otherwise. With bit 14 clear, neither pulses.
- R8: While mode bit 0 (receive enable) is set and the current receive descriptor has status bit 15 (empty) set, rx_ready is high and rx_buf_addr carries that descriptor's address word.
- R9: A frame reported by rx_done while rx_ready is high is written back as {rx_len, 0, kept bit 14, kept bit 13, 4'b0, rx_flags}. The flags are: bit 8 control frame, 7 miss, 6 overrun, 5 invalid symbol, 4 dribble nibble, 3 too long, 2 short, 1 CRC error, 0 late collision.
- R10: The receive ring starts at index N. After a descriptor with bit 13 set, or after index NUM_BD-1, the receive pointer returns to index N.
- R11: If status bit 14 is set, a receive write-back pulses evt_rx_err when any of rx_flags bits 6, 5, 3, 2, 1 or 0 is set, and pulses evt_rx_done otherwise. With bit 14 clear, neither pulses.
- R12: An rx_done with receive enabled and rx_ready low drops the frame. No descriptor is changed and evt_busy pulses.
- R13: With transmit disabled, tx_req stays low even over ready descriptors. With receive disabled, rx_ready stays low and rx_done changes nothing and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 11 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after host_re |
| tx_req | output | 1 | Transmit job offered to the MAC core |
| tx_len | output | 16 | Length of the offered job |
| tx_buf_addr | output | 32 | Buffer address of the offered job |
| tx_done | input | 1 | MAC core finished the offered job |
| tx_status | input | 9 | Outcome flags and retry count for the finished job |
| rx_ready | output | 1 | An empty receive descriptor is available |
| rx_buf_addr | output | 32 | Buffer address of that descriptor |
| rx_done | input | 1 | MAC core finished a frame |
| rx_len | input | 16 | Frame length including the 4-byte CRC |
| rx_flags | input | 9 | Receive status flags |
| evt_tx_done | output | 1 | Transmit frame event pulse |
| evt_tx_err | output | 1 | Transmit error event pulse |
| evt_rx_done | output | 1 | Receive frame event pulse |
| evt_rx_err | output | 1 | Receive error event pulse |
| evt_busy | output | 1 | Frame dropped for lack of an empty descriptor |

## Verification
The hardest state to reach is the return of each pointer to the start of its ring. The pointers cannot be seen from the ports, so the only evidence is which descriptor the engine offers next. The stimulus drives the transmit ring once around through a wrap bit and once through the end of a four-entry region. After each lap it re-arms descriptor 0 with a new length and expects that length on tx_len. On the receive side, three frames fill a ring closed by a wrap bit. The next frame must then find descriptor N still owned by the host, so it is dropped with a busy event. Re-arming descriptor N must bring back its address on rx_buf_addr.

// File: rtl/eth_bd_pkg.sv
// Package: shared constants and state encodings for the descriptor ring engine.
// Assumes: descriptor status words use the bit layout stated in the brief.
package eth_bd_pkg;

    localparam int unsigned REG_MODE  = 11'h000;
    localparam int unsigned REG_SPLIT = 11'h020;

    localparam int unsigned BIT_OWN  = 15;   // ready (tx) / empty (rx)
    localparam int unsigned BIT_IRQ  = 14;
    localparam int unsigned BIT_WRAP = 13;

    localparam logic [8:0] TX_ERR_MASK = 9'h10D;  // underrun, retry limit, late coll, carrier
    localparam logic [8:0] RX_ERR_MASK = 9'h06F;  // overrun, symbol, long, short, crc, late coll

    typedef enum logic [1:0] {
        TX_POLL = 2'd0,
        TX_BUSY = 2'd1,
        TX_WB   = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_WB   = 1'b1
    } rx_state_e;

endpackage

// File: rtl/eth_bd_regs.sv
// Module: mode and split registers of the ring engine.
// Does: holds the two enable bits and the transmit descriptor count, clamps
//       the count at NUM_BD, and returns register read data combinationally.
// Assumes: the caller only strobes we for addresses below the descriptor area.
module eth_bd_regs #(
    parameter  int NUM_BD = 128,
    parameter  int ADDR_W = 11,
    localparam int CNT_W  = $clog2(NUM_BD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              rx_en,
    output logic              tx_en,
    output logic [CNT_W-1:0]  tx_cnt,
    output logic [31:0]       rd_data
);
    import eth_bd_pkg::*;

    logic [CNT_W-1:0] cnt_next;

    // Clamp a requested transmit count to the table size.
    always_comb begin
        if (wdata > 32'(NUM_BD)) cnt_next = CNT_W'(NUM_BD);
        else                     cnt_next = wdata[CNT_W-1:0];
    end

    // Register updates from host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en  <= 1'b0;
            tx_en  <= 1'b0;
            tx_cnt <= CNT_W'(NUM_BD / 2);
        end else if (we) begin
            if (addr == ADDR_W'(REG_MODE)) begin
                rx_en <= wdata[0];
                tx_en <= wdata[1];
            end
            if (addr == ADDR_W'(REG_SPLIT)) tx_cnt <= cnt_next;
        end
    end

    // Register read mux.
    always_comb begin
        rd_data = 32'h0;
        if (addr == ADDR_W'(REG_MODE))  rd_data = {30'h0, tx_en, rx_en};
        if (addr == ADDR_W'(REG_SPLIT)) rd_data = 32'(tx_cnt);
    end

    p_cnt_clamped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CNT_W'(NUM_BD));

endmodule

// File: rtl/eth_bd_mem.sv
// Module: descriptor storage with one shared write port.
// Does: stores 2*NUM_BD words, status at even and address at odd word index.
//       Reads are combinational for the host and both ring walkers. Writes are
//       arbitrated: host first, then transmit write-back, then receive write-back.
// Assumes: storage has no reset; the host initialises descriptors before enabling.
module eth_bd_mem #(
    parameter  int NUM_BD = 128,
    localparam int IDX_W  = $clog2(NUM_BD),
    localparam int WI_W   = IDX_W + 1
) (
    input  logic             clk,
    input  logic             host_we,
    input  logic [WI_W-1:0]  host_idx,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_word,
    input  logic [IDX_W-1:0] tx_rd_idx,
    output logic [22:0]      tx_head,
    output logic [31:0]      tx_buf,
    input  logic [IDX_W-1:0] rx_rd_idx,
    output logic [2:0]       rx_head,
    output logic [31:0]      rx_buf,
    input  logic             tx_wr_req,
    input  logic [IDX_W-1:0] tx_wr_idx,
    input  logic [31:0]      tx_wr_data,
    output logic             tx_wr_gnt,
    input  logic             rx_wr_req,
    input  logic [IDX_W-1:0] rx_wr_idx,
    input  logic [31:0]      rx_wr_data,
    output logic             rx_wr_gnt
);
    localparam int WORDS = 2 * NUM_BD;

    logic [31:0]     store [WORDS];
    logic            wr_en;
    logic [WI_W-1:0] wr_idx;
    logic [31:0]     wr_data;
    logic [31:0]     tx_stat_w;
    logic [31:0]     rx_stat_w;

    // Arbitrate the single write port.
    always_comb begin
        tx_wr_gnt = tx_wr_req && !host_we;
        rx_wr_gnt = rx_wr_req && !host_we && !tx_wr_req;
        wr_en     = host_we || tx_wr_gnt || rx_wr_gnt;
        if (host_we) begin
            wr_idx  = host_idx;
            wr_data = host_wdata;
        end else if (tx_wr_gnt) begin
            wr_idx  = {tx_wr_idx, 1'b0};
            wr_data = tx_wr_data;
        end else begin
            wr_idx  = {rx_wr_idx, 1'b0};
            wr_data = rx_wr_data;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_idx] <= wr_data;
    end

    // Combinational read ports.
    always_comb begin
        host_word = store[host_idx];
        tx_stat_w = store[{tx_rd_idx, 1'b0}];
        tx_buf    = store[{tx_rd_idx, 1'b1}];
        rx_stat_w = store[{rx_rd_idx, 1'b0}];
        rx_buf    = store[{rx_rd_idx, 1'b1}];
        tx_head   = tx_stat_w[31:9];
        rx_head   = rx_stat_w[15:13];
    end

endmodule

// File: rtl/eth_bd_tx_ring.sv
// Module: transmit ring walker.
// Does: polls the current transmit descriptor, offers ready jobs to the MAC
//       core, writes the outcome back and advances with wrap handling.
// Assumes: tx_cnt is only changed by the host while transmit is disabled.
module eth_bd_tx_ring #(
    parameter  int NUM_BD = 128,
    localparam int IDX_W  = $clog2(NUM_BD),
    localparam int CNT_W  = $clog2(NUM_BD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [22:0]      bd_head,
    input  logic [31:0]      bd_buf,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_req,
    output logic [IDX_W-1:0] wr_idx,
    output logic [31:0]      wr_data,
    input  logic             wr_gnt,
    output logic             mac_req,
    output logic [15:0]      mac_len,
    output logic [31:0]      mac_addr,
    input  logic             mac_done,
    input  logic [8:0]       mac_stat,
    output logic             evt_done,
    output logic             evt_err
);
    import eth_bd_pkg::*;

    tx_state_e        state;
    logic [IDX_W-1:0] ptr;
    logic [IDX_W-1:0] ptr_next;
    logic [15:0]      len_q;
    logic [31:0]      addr_q;
    logic [5:0]       ctrl_q;     // status bits 14:9
    logic [8:0]       stat_q;
    logic             ptr_out;
    logic             is_err;

    // Next pointer: wrap bit or end of transmit region returns to 0.
    always_comb begin
        ptr_out = (CNT_W'(ptr) >= tx_cnt);
        if (ctrl_q[BIT_WRAP-9] || (CNT_W'(ptr) + CNT_W'(1) >= tx_cnt))
            ptr_next = '0;
        else
            ptr_next = ptr + IDX_W'(1);
        is_err = |(stat_q & TX_ERR_MASK);
    end

    // Walker state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= TX_POLL;
            ptr      <= '0;
            len_q    <= '0;
            addr_q   <= '0;
            ctrl_q   <= '0;
            stat_q   <= '0;
            evt_done <= 1'b0;
            evt_err  <= 1'b0;
        end else begin
            evt_done <= 1'b0;
            evt_err  <= 1'b0;
            case (state)
                TX_POLL: begin
                    if (ptr_out) begin
                        ptr <= '0;
                    end else if (tx_en && bd_head[BIT_OWN-9]) begin
                        len_q  <= bd_head[22:7];
                        ctrl_q <= bd_head[5:0];
                        addr_q <= bd_buf;
                        state  <= TX_BUSY;
                    end
                end
                TX_BUSY: begin
                    if (mac_done) begin
                        stat_q <= mac_stat;
                        state  <= TX_WB;
                    end
                end
                TX_WB: begin
                    if (wr_gnt) begin
                        ptr      <= ptr_next;
                        evt_done <= ctrl_q[BIT_IRQ-9] && !is_err;
                        evt_err  <= ctrl_q[BIT_IRQ-9] && is_err;
                        state    <= TX_POLL;
                    end
                end
                default: state <= TX_POLL;
            endcase
        end
    end

    // Outputs toward storage and the MAC core.
    always_comb begin
        rd_idx   = ptr;
        wr_idx   = ptr;
        wr_req   = (state == TX_WB);
        wr_data  = {len_q, 1'b0, ctrl_q, stat_q};
        mac_req  = (state == TX_BUSY);
        mac_len  = len_q;
        mac_addr = addr_q;
    end

    p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mac_req && !mac_done |=> mac_req);

    p_req_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mac_req && $past(mac_req) |-> $stable(mac_len) && $stable(mac_addr));

    p_done_leaves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mac_req && mac_done |=> !mac_req);

    p_idle_tx_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en && state == TX_POLL |=> !mac_req);

endmodule

// File: rtl/eth_bd_rx_ring.sv
// Module: receive ring walker.
// Does: offers the current empty receive descriptor to the MAC core, records
//       finished frames, drops frames with a busy event when none is empty.
// Assumes: the receive ring begins at index tx_cnt; the pointer is kept as an
//          offset from it.
module eth_bd_rx_ring #(
    parameter  int NUM_BD = 128,
    localparam int IDX_W  = $clog2(NUM_BD),
    localparam int CNT_W  = $clog2(NUM_BD + 1),
    localparam int SUM_W  = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [2:0]       bd_head,    // status bits 15:13
    input  logic [31:0]      bd_buf,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_req,
    output logic [IDX_W-1:0] wr_idx,
    output logic [31:0]      wr_data,
    input  logic             wr_gnt,
    output logic             mac_ready,
    output logic [31:0]      mac_addr,
    input  logic             mac_done,
    input  logic [15:0]      mac_len,
    input  logic [8:0]       mac_flags,
    output logic             evt_done,
    output logic             evt_err,
    output logic             evt_busy
);
    import eth_bd_pkg::*;

    rx_state_e        state;
    logic [IDX_W-1:0] off;
    logic [IDX_W-1:0] off_next;
    logic [SUM_W-1:0] abs_idx;
    logic             in_range;
    logic [15:0]      len_q;
    logic [8:0]       flags_q;
    logic             irq_q;
    logic             wrap_q;
    logic             is_err;

    // Absolute index, range check and next offset.
    always_comb begin
        abs_idx  = SUM_W'(tx_cnt) + SUM_W'(off);
        in_range = (abs_idx < SUM_W'(NUM_BD));
        if (wrap_q || (abs_idx + SUM_W'(1) >= SUM_W'(NUM_BD)))
            off_next = '0;
        else
            off_next = off + IDX_W'(1);
        is_err    = |(flags_q & RX_ERR_MASK);
        mac_ready = rx_en && (state == RX_IDLE) && in_range && bd_head[2];
    end

    // Walker state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            off      <= '0;
            len_q    <= '0;
            flags_q  <= '0;
            irq_q    <= 1'b0;
            wrap_q   <= 1'b0;
            evt_done <= 1'b0;
            evt_err  <= 1'b0;
            evt_busy <= 1'b0;
        end else begin
            evt_done <= 1'b0;
            evt_err  <= 1'b0;
            evt_busy <= rx_en && mac_done && !mac_ready;
            case (state)
                RX_IDLE: begin
                    if (!in_range) begin
                        off <= '0;
                    end else if (mac_done && mac_ready) begin
                        len_q   <= mac_len;
                        flags_q <= mac_flags;
                        irq_q   <= bd_head[1];
                        wrap_q  <= bd_head[0];
                        state   <= RX_WB;
                    end
                end
                RX_WB: begin
                    if (wr_gnt) begin
                        off      <= off_next;
                        evt_done <= irq_q && !is_err;
                        evt_err  <= irq_q && is_err;
                        state    <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // Outputs toward storage and the MAC core.
    always_comb begin
        rd_idx   = abs_idx[IDX_W-1:0];
        wr_idx   = abs_idx[IDX_W-1:0];
        wr_req   = (state == RX_WB);
        wr_data  = {len_q, 1'b0, irq_q, wrap_q, 4'b0000, flags_q};
        mac_addr = bd_buf;
    end

    p_drop_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && mac_done && !mac_ready |=> evt_busy);

endmodule

// File: rtl/eth_bd_ring_engine.sv
// Module: top of the descriptor ring engine.
// Does: decodes the host bus into registers and descriptor storage, registers
//       host read data, and connects both ring walkers to storage and the MAC.
// Assumes: NUM_BD <= 128 so the table fits 0x400..0x7FF.
module eth_bd_ring_engine #(
    parameter  int NUM_BD = 128,
    localparam int ADDR_W = 11,
    localparam int IDX_W  = $clog2(NUM_BD),
    localparam int WI_W   = IDX_W + 1,
    localparam int CNT_W  = $clog2(NUM_BD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              tx_req,
    output logic [15:0]       tx_len,
    output logic [31:0]       tx_buf_addr,
    input  logic              tx_done,
    input  logic [8:0]        tx_status,
    output logic              rx_ready,
    output logic [31:0]       rx_buf_addr,
    input  logic              rx_done,
    input  logic [15:0]       rx_len,
    input  logic [8:0]        rx_flags,
    output logic              evt_tx_done,
    output logic              evt_tx_err,
    output logic              evt_rx_done,
    output logic              evt_rx_err,
    output logic              evt_busy
);
    logic             bd_area;
    logic [7:0]       word_full;
    logic             bd_hit;
    logic [WI_W-1:0]  host_widx;
    logic             reg_we;
    logic             bd_we;
    logic [31:0]      reg_rd;
    logic [31:0]      bd_rd;
    logic             rx_en;
    logic             tx_en;
    logic [CNT_W-1:0] tx_cnt;

    logic [IDX_W-1:0] tx_rd_idx, tx_wr_idx, rx_rd_idx, rx_wr_idx;
    logic [22:0]      tx_head;
    logic [2:0]       rx_head;
    logic [31:0]      tx_buf, rx_buf, tx_wr_data, rx_wr_data;
    logic             tx_wr_req, tx_wr_gnt, rx_wr_req, rx_wr_gnt;

    // Host address decode.
    always_comb begin
        bd_area   = host_addr[10];
        word_full = host_addr[9:2];
        bd_hit    = bd_area && (32'(word_full) < 32'(2 * NUM_BD));
        host_widx = word_full[WI_W-1:0];
        reg_we    = host_we && !bd_area;
        bd_we     = host_we && bd_hit;
    end

    // Registered host read data.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= 32'h0;
        else if (host_re) host_rdata <= bd_hit ? bd_rd : (bd_area ? 32'h0 : reg_rd);
    end

    eth_bd_regs #(.NUM_BD(NUM_BD), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(host_addr),
        .wdata(host_wdata), .rx_en(rx_en), .tx_en(tx_en),
        .tx_cnt(tx_cnt), .rd_data(reg_rd)
    );

    eth_bd_mem #(.NUM_BD(NUM_BD)) u_mem (
        .clk(clk), .host_we(bd_we), .host_idx(host_widx),
        .host_wdata(host_wdata), .host_word(bd_rd),
        .tx_rd_idx(tx_rd_idx), .tx_head(tx_head), .tx_buf(tx_buf),
        .rx_rd_idx(rx_rd_idx), .rx_head(rx_head), .rx_buf(rx_buf),
        .tx_wr_req(tx_wr_req), .tx_wr_idx(tx_wr_idx),
        .tx_wr_data(tx_wr_data), .tx_wr_gnt(tx_wr_gnt),
        .rx_wr_req(rx_wr_req), .rx_wr_idx(rx_wr_idx),
        .rx_wr_data(rx_wr_data), .rx_wr_gnt(rx_wr_gnt)
    );

    eth_bd_tx_ring #(.NUM_BD(NUM_BD)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_cnt(tx_cnt),
        .bd_head(tx_head), .bd_buf(tx_buf), .rd_idx(tx_rd_idx),
        .wr_req(tx_wr_req), .wr_idx(tx_wr_idx), .wr_data(tx_wr_data),
        .wr_gnt(tx_wr_gnt), .mac_req(tx_req), .mac_len(tx_len),
        .mac_addr(tx_buf_addr), .mac_done(tx_done), .mac_stat(tx_status),
        .evt_done(evt_tx_done), .evt_err(evt_tx_err)
    );

    eth_bd_rx_ring #(.NUM_BD(NUM_BD)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_cnt(tx_cnt),
        .bd_head(rx_head), .bd_buf(rx_buf), .rd_idx(rx_rd_idx),
        .wr_req(rx_wr_req), .wr_idx(rx_wr_idx), .wr_data(rx_wr_data),
        .wr_gnt(rx_wr_gnt), .mac_ready(rx_ready), .mac_addr(rx_buf_addr),
        .mac_done(rx_done), .mac_len(rx_len), .mac_flags(rx_flags),
        .evt_done(evt_rx_done), .evt_err(evt_rx_err), .evt_busy(evt_busy)
    );

endmodule

// File: tb/tb_eth_bd_ring_engine.sv
module tb_eth_bd_ring_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0, host_re = 1'b0;
    logic [10:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        tx_req;
    logic [15:0] tx_len;
    logic [31:0] tx_buf_addr;
    logic        tx_done = 1'b0;
    logic [8:0]  tx_status = '0;
    logic        rx_ready;
    logic [31:0] rx_buf_addr;
    logic        rx_done = 1'b0;
    logic [15:0] rx_len = '0;
    logic [8:0]  rx_flags = '0;
    logic        evt_tx_done, evt_tx_err, evt_rx_done, evt_rx_err, evt_busy;

    int n_total = 0;
    int n_bad = 0;
    int c_txd = 0, c_txe = 0, c_rxd = 0, c_rxe = 0, c_busy = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eth_bd_ring_engine dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_req(tx_req), .tx_len(tx_len), .tx_buf_addr(tx_buf_addr),
        .tx_done(tx_done), .tx_status(tx_status), .rx_ready(rx_ready),
        .rx_buf_addr(rx_buf_addr), .rx_done(rx_done), .rx_len(rx_len),
        .rx_flags(rx_flags), .evt_tx_done(evt_tx_done), .evt_tx_err(evt_tx_err),
        .evt_rx_done(evt_rx_done), .evt_rx_err(evt_rx_err), .evt_busy(evt_busy)
    );

    // Event pulse counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (evt_tx_done) c_txd++;
            if (evt_tx_err)  c_txe++;
            if (evt_rx_done) c_rxd++;
            if (evt_rx_err)  c_rxe++;
            if (evt_busy)    c_busy++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hrd(input logic [10:0] a, output logic [31:0] d);
        @(negedge clk);
        host_re = 1'b1; host_addr = a;
        @(negedge clk);
        host_re = 1'b0;
        d = host_rdata;
    endtask

    function automatic logic [10:0] bd_at(input int idx, input int word);
        return 11'(32'h400 + 8 * idx + 4 * word);
    endfunction

    task automatic arm(input int idx, input logic [31:0] stat, input logic [31:0] addr);
        hwr(bd_at(idx, 1), addr);
        hwr(bd_at(idx, 0), stat);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // MAC stub: wait for an offered job, check it, finish it with a status.
    task automatic mac_tx(input string tag, input logic [15:0] el, input logic [31:0] ea,
                          input logic [8:0] st);
        int waited = 0;
        @(negedge clk);
        while (!tx_req && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        chk({tag, " tx_req"}, 32'(tx_req), 32'h1);
        chk({tag, " tx_len"}, 32'(tx_len), 32'(el));
        chk({tag, " tx_buf_addr"}, tx_buf_addr, ea);
        tx_done = 1'b1; tx_status = st;
        @(negedge clk);
        chk({tag, " tx_req dropped"}, 32'(tx_req), 32'h0);
        tx_done = 1'b0; tx_status = '0;
        idle(3);
    endtask

    task automatic mac_rx(input logic [15:0] l, input logic [8:0] f);
        @(negedge clk);
        rx_done = 1'b1; rx_len = l; rx_flags = f;
        @(negedge clk);
        rx_done = 1'b0; rx_len = '0; rx_flags = '0;
        idle(3);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 tx_req", 32'(tx_req), 32'h0);
        chk("R1 rx_ready", 32'(rx_ready), 32'h0);
        chk("R1 events", 32'({evt_tx_done, evt_tx_err, evt_rx_done, evt_rx_err, evt_busy}), 32'h0);
        hrd(11'h000, d); chk("R1 mode", d, 32'h0);
        hrd(11'h020, d); chk("R1 split", d, 32'd64);
    endtask

    task automatic t_host_access;
        logic [31:0] d;
        hwr(bd_at(5, 1), 32'hDEAD_BEEF);
        hwr(bd_at(5, 0), 32'h1234_0000);
        hrd(bd_at(5, 1), d); chk("R2 address word", d, 32'hDEAD_BEEF);
        hrd(bd_at(5, 0), d); chk("R2 status word", d, 32'h1234_0000);
        hwr(11'h020, 32'd200);
        hrd(11'h020, d); chk("R3 clamp", d, 32'd128);
        hwr(11'h020, 32'd4);
        hrd(11'h020, d); chk("R3 plain", d, 32'd4);
    endtask

    task automatic t_disabled;
        logic [31:0] d;
        int b0;
        arm(0, 32'h0064_C000, 32'hA000_0000);
        arm(4, 32'h0000_C000, 32'hB000_0040);
        idle(10);
        chk("R13 tx idle", 32'(tx_req), 32'h0);
        chk("R13 rx not ready", 32'(rx_ready), 32'h0);
        b0 = c_busy;
        mac_rx(16'd99, 9'h000);
        chk("R13 no busy", 32'(c_busy - b0), 32'h0);
        hrd(bd_at(4, 0), d); chk("R13 rx bd untouched", d, 32'h0000_C000);
    endtask

    task automatic t_tx_basic;
        logic [31:0] d;
        int d0, e0;
        d0 = c_txd; e0 = c_txe;
        hwr(11'h000, 32'h2);
        mac_tx("R4 bd0", 16'd100, 32'hA000_0000, 9'h032);
        hrd(bd_at(0, 0), d); chk("R5 writeback bd0", d, 32'h0064_4032);
        chk("R7 done event", 32'(c_txd - d0), 32'h1);
        chk("R7 no err event", 32'(c_txe - e0), 32'h0);
    endtask

    task automatic t_tx_irq_err;
        logic [31:0] d;
        int d0, e0;
        d0 = c_txd; e0 = c_txe;
        arm(1, 32'h003C_9000, 32'hA000_0100);
        mac_tx("R4 bd1", 16'd60, 32'hA000_0100, 9'h100);
        hrd(bd_at(1, 0), d); chk("R5 writeback bd1", d, 32'h003C_1100);
        chk("R7 silent without irq", 32'(c_txe - e0), 32'h0);
        arm(2, 32'h0040_E000, 32'hA000_0200);
        mac_tx("R4 bd2", 16'd64, 32'hA000_0200, 9'h004);
        hrd(bd_at(2, 0), d); chk("R5 writeback bd2", d, 32'h0040_6004);
        chk("R7 err event", 32'(c_txe - e0), 32'h1);
        chk("R7 no done event", 32'(c_txd - d0), 32'h0);
    endtask

    task automatic t_tx_wrap;
        logic [31:0] d;
        // Pointer must be back at 0 after the wrap bit on bd2.
        arm(3, 32'h0013_8000, 32'hA000_0300);
        arm(2, 32'h0012_8000, 32'hA000_0200);
        arm(1, 32'h0011_8000, 32'hA000_0100);
        arm(0, 32'h0010_8000, 32'hA000_0000);
        mac_tx("R6 after wrap bit", 16'h10, 32'hA000_0000, 9'h0);
        mac_tx("R6 step 1", 16'h11, 32'hA000_0100, 9'h0);
        mac_tx("R6 step 2", 16'h12, 32'hA000_0200, 9'h0);
        mac_tx("R6 step 3", 16'h13, 32'hA000_0300, 9'h0);
        hrd(bd_at(3, 0), d); chk("R5 writeback bd3", d, 32'h0013_0000);
        arm(0, 32'h0055_8000, 32'hA000_0000);
        mac_tx("R6 after region end", 16'h55, 32'hA000_0000, 9'h0);
    endtask

    task automatic t_rx_path;
        logic [31:0] d;
        int d0, e0, b0;
        d0 = c_rxd; e0 = c_rxe; b0 = c_busy;
        arm(5, 32'h0000_8000, 32'hB000_0050);
        arm(6, 32'h0000_E000, 32'hB000_0060);
        hwr(11'h000, 32'h3);
        chk("R8 ready", 32'(rx_ready), 32'h1);
        chk("R8 addr bd4", rx_buf_addr, 32'hB000_0040);
        mac_rx(16'd68, 9'h000);
        hrd(bd_at(4, 0), d); chk("R9 writeback bd4", d, 32'h0044_4000);
        chk("R11 done event", 32'(c_rxd - d0), 32'h1);
        chk("R8 addr bd5", rx_buf_addr, 32'hB000_0050);
        mac_rx(16'd70, 9'h002);
        hrd(bd_at(5, 0), d); chk("R9 writeback bd5", d, 32'h0046_0002);
        chk("R11 silent without irq", 32'(c_rxe - e0), 32'h0);
        mac_rx(16'd72, 9'h040);
        hrd(bd_at(6, 0), d); chk("R9 writeback bd6", d, 32'h0048_6040);
        chk("R11 err event", 32'(c_rxe - e0), 32'h1);
        chk("R10 back at N, owned by host", 32'(rx_ready), 32'h0);
        mac_rx(16'd80, 9'h000);
        chk("R12 busy event", 32'(c_busy - b0), 32'h1);
        hrd(bd_at(4, 0), d); chk("R12 bd4 unchanged", d, 32'h0044_4000);
        hwr(bd_at(4, 0), 32'h0000_C000);
        chk("R10 ready again", 32'(rx_ready), 32'h1);
        chk("R10 addr returns to N", rx_buf_addr, 32'hB000_0040);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_host_access();
        t_disabled();
        t_tx_basic();
        t_tx_irq_err();
        t_tx_wrap();
        t_rx_path();
        idle(2);
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule